// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is an I2C target that lets a bus master read and write a byte-wide register file sitting beside it. It samples SCL and SDA in the system clock domain, finds start and stop conditions, and matches a 7-bit device address. Six address bits are fixed and the lowest one is taken from a strap pin, which is latched while reset is asserted. SDA is open-drain, so the block drives only an output enable: while the enable is high the line is pulled low.

After a matching write address, the next byte loads a register pointer. Its MSB turns on auto-increment and its low bits select the register. Each later byte is written to the register the pointer selects. A repeated start followed by the read address returns bytes from the current pointer, MSB first, until the master answers with a NACK. With auto-increment on, the pointer steps after each byte moved. With it off, the pointer stays where it is. The register file sits outside the block and is reached through a write strobe, an address, write data and combinational read data.

Top module: `i2c_reg_slave`

## Requirements
- R1: While and after reset, with no bus traffic, sda_oe_o and reg_we_o are low.
- R2: The first byte after a start is seven address bits, MSB first, and then a direction bit (1 = read, 0 = write). The block acknowledges an address equal to 100101 followed by the strap bit by holding sda_oe_o high through the ninth SCL clock.
- R3: After an address that does not match, the block sends no ACK. It drives nothing and writes nothing until the next start.
- R4: strap_i is sampled only while rst_ni is low. A change on strap_i after reset has no effect on the address that is matched.
- R5: In a write, the byte after the address is the pointer. Bit 7 is the auto-increment flag and bits 6:0 select the register. The pointer byte is acknowledged.
- R6: Each data byte that follows the pointer in a write is acknowledged and is written, with a single-cycle reg_we_o pulse, to the register the pointer selects.
- R7: With auto-increment set, consecutive written bytes go to consecutive registers.
- R8: With auto-increment clear, consecutive written bytes all go to the same register.
- R9: A repeated start followed by the read address returns the register at the current pointer, MSB first. SDA is held low for a 0 bit and released for a 1 bit.
- R10: In a read burst that the master acknowledges, the pointer advances after each byte when auto-increment is set. When it is clear, the same register is sent again.
- R11: A NACK from the master ends the read. The block releases SDA and drives nothing further until the next start.
- R12: A stop condition (SDA rising while SCL is high) returns the block to idle at any bit position. A partial byte is discarded.
- R13: A start condition (SDA falling while SCL is high) restarts address reception at any bit position. sda_oe_o changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | High pulls SDA low |
| strap_i | input | 1 | Address LSB strap, latched during reset |
| reg_we_o | output | 1 | Register write strobe |
| reg_addr_o | output | PTR_W | Register pointer, used for both write and read |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o |

## Verification
A written byte and the pointer step it causes fall in the same cycle. The strobe is raised with the old pointer on reg_addr_o, and the pointer moves on the next clock. Auto-increment bursts written back to back provoke this case. They are judged by reading the register file at the ports: every target register must hold its byte and the register past the burst must be unchanged. A stop or start that arrives in the middle of a byte coincides with the bit shift. The bench breaks off a byte partway and then checks that the next complete transaction lands correctly and that nothing was written.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WR,
    ST_RD
  } slv_state_e;

  localparam logic [5:0] DEV_ADDR_HI = 6'b100101;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edges only count while SCL stayed high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_ptr_reg.sv
module i2c_ptr_reg #(
  parameter int PTR_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [7:0]       load_byte_i,
  input  logic             step_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             incr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o  <= '0;
      incr_o <= 1'b0;
    end else if (load_i) begin
      ptr_o  <= load_byte_i[PTR_W-1:0];
      incr_o <= load_byte_i[7];
    end else if (step_i && incr_o) begin
      ptr_o  <= ptr_o + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2c_slv_pkg::*;
#(
  parameter int PTR_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             strap_i,
  output logic             reg_we_o,
  output logic [PTR_W-1:0] reg_addr_o,
  output logic [7:0]       reg_wdata_o,
  input  logic [7:0]       reg_rdata_i
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic strap_q;
  slv_state_e state;
  logic [CNT_W-1:0] cnt;
  logic ack_ph, rw_q;
  logic [7:0] shreg, tx;
  logic ptr_load, rd_step, incr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  // write strobe steps the pointer one cycle after it lands
  i2c_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ptr_load), .load_byte_i(shreg),
    .step_i(reg_we_o | rd_step), .ptr_o(reg_addr_o), .incr_o(incr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strap_q <= strap_i;
    else         strap_q <= strap_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      ack_ph      <= 1'b0;
      rw_q        <= 1'b0;
      shreg       <= '0;
      tx          <= '0;
      sda_oe_o    <= 1'b0;
      reg_we_o    <= 1'b0;
      reg_wdata_o <= '0;
      ptr_load    <= 1'b0;
      rd_step     <= 1'b0;
    end else begin
      reg_we_o <= 1'b0;
      ptr_load <= 1'b0;
      rd_step  <= 1'b0;
      if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
        ack_ph   <= 1'b0;
        cnt      <= '0;
      end else if (start_det) begin
        state    <= ST_ADDR;
        sda_oe_o <= 1'b0;
        ack_ph   <= 1'b0;
        cnt      <= '0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (!ack_ph && cnt < LAST_BIT) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (ack_ph && state == ST_RD && sda_s) begin
            state  <= ST_IDLE;  // master NACK
            ack_ph <= 1'b0;
            cnt    <= '0;
          end
        end else if (scl_fall) begin
          if (ack_ph) begin
            ack_ph   <= 1'b0;
            cnt      <= '0;
            sda_oe_o <= 1'b0;
            unique case (state)
              ST_ADDR: begin
                if (rw_q) begin
                  state    <= ST_RD;
                  tx       <= reg_rdata_i;
                  sda_oe_o <= ~reg_rdata_i[7];
                end else begin
                  state <= ST_PTR;
                end
              end
              ST_PTR: state <= ST_WR;
              ST_RD: begin
                tx       <= reg_rdata_i;
                sda_oe_o <= ~reg_rdata_i[7];
              end
              default: ;
            endcase
          end else if (cnt == LAST_BIT) begin
            unique case (state)
              ST_ADDR: begin
                if (shreg[7:1] == {DEV_ADDR_HI, strap_q}) begin
                  rw_q     <= shreg[0];
                  sda_oe_o <= 1'b1;
                  ack_ph   <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                  cnt   <= '0;
                end
              end
              ST_PTR: begin
                ptr_load <= 1'b1;
                sda_oe_o <= 1'b1;
                ack_ph   <= 1'b1;
              end
              ST_WR: begin
                reg_we_o    <= 1'b1;
                reg_wdata_o <= shreg;
                sda_oe_o    <= 1'b1;
                ack_ph      <= 1'b1;
              end
              ST_RD: begin
                sda_oe_o <= 1'b0;
                ack_ph   <= 1'b1;
                rd_step  <= 1'b1;
              end
              default: ;
            endcase
          end else if (state == ST_RD && cnt != '0) begin
            tx       <= {tx[6:0], 1'b0};
            sda_oe_o <= ~tx[6];
          end
        end
      end
    end
  end

  logic unused_incr;
  assign unused_incr = incr;
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe_o,
  input logic reg_we_o
);
  assert_we_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  assert_we_scl_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> !scl_s);

  assert_oe_scl_low_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);

  assert_stop_release_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o);

  assert_start_release_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_oe_o);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe_o(sda_oe_o), .reg_we_o(reg_we_o)
);

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int PTR_W = 7;
  localparam int NREG = 1 << PTR_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b1;
  logic sda_bus, sda_oe, we;
  logic [PTR_W-1:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] rf [NREG];
  logic [7:0] exp_rf [NREG];

  int nchk = 0, nfail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] rd_val;
  event rd_done;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;
  assign rdata   = rf[addr];

  i2c_reg_slave #(.PTR_W(PTR_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(strap), .reg_we_o(we), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) rf[i] <= 8'(i) ^ 8'h5A;
    end else if (we) begin
      rf[addr] <= wdata;
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // scoreboard monitor for read bytes
  initial begin
    forever begin
      @(rd_done);
      if (exp_q.size() == 0) chk("R9 unexpected read", rd_val, 8'hxx);
      else chk(tag_q.pop_front(), rd_val, exp_q.pop_front());
    end
  end

  task automatic qtr();
    repeat (5) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    qtr(); sda_m = b;
    qtr(); scl_m = 1'b1;
    qtr(); s = sda_bus;
    qtr(); scl_m = 1'b0;
  endtask

  task automatic i2c_start();
    qtr(); sda_m = 1'b1;
    qtr(); scl_m = 1'b1;
    qtr(); sda_m = 1'b0;
    qtr(); scl_m = 1'b0;
  endtask

  task automatic i2c_stop();
    qtr(); sda_m = 1'b0;
    qtr(); scl_m = 1'b1;
    qtr(); sda_m = 1'b1;
    qtr();
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic rd_byte(input logic mack);
    logic s;
    logic [7:0] d;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~mack, s);
    sda_m = 1'b1;
    rd_val = d;
    ->rd_done;
    @(negedge clk);
  endtask

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic a, s;
    for (int i = 0; i < NREG; i++) exp_rf[i] = 8'(i) ^ 8'h5A;
    repeat (5) @(negedge clk);
    chk("R1 oe in reset", {7'd0, sda_oe}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    strap = 1'b0;  // must be ignored: latched as 1 during reset
    repeat (10) @(negedge clk);
    chk("R1 oe idle", {7'd0, sda_oe}, 8'h00);
    chk("R1 we idle", {7'd0, we}, 8'h00);

    // single write, address 1001011 (strap latched 1)
    i2c_start();
    wr_byte(8'h96, a); chk("R2 R4 addr ack", {7'd0, a}, 8'h01);
    wr_byte(8'h05, a); chk("R5 ptr ack", {7'd0, a}, 8'h01);
    wr_byte(8'hA5, a); chk("R6 data ack", {7'd0, a}, 8'h01);
    i2c_stop();
    exp_rf[5] = 8'hA5;
    chk("R6 single write", rf[5], exp_rf[5]);

    // mismatched address (strap 0 now on pin) must be refused
    i2c_start();
    wr_byte(8'h94, a); chk("R3 R4 mismatch nack", {7'd0, a}, 8'h00);
    wr_byte(8'h07, a); chk("R3 no ack ptr", {7'd0, a}, 8'h00);
    wr_byte(8'h33, a); chk("R3 no ack data", {7'd0, a}, 8'h00);
    i2c_stop();
    chk("R3 no write", rf[7], exp_rf[7]);

    // auto-increment burst write
    i2c_start();
    wr_byte(8'h96, a);
    wr_byte(8'h90, a);
    wr_byte(8'h11, a); wr_byte(8'h22, a); wr_byte(8'h33, a);
    i2c_stop();
    exp_rf[16] = 8'h11; exp_rf[17] = 8'h22; exp_rf[18] = 8'h33;
    chk("R7 burst r16", rf[16], exp_rf[16]);
    chk("R7 burst r17", rf[17], exp_rf[17]);
    chk("R7 burst r18", rf[18], exp_rf[18]);
    chk("R7 burst r19 untouched", rf[19], exp_rf[19]);

    // fixed-pointer write
    i2c_start();
    wr_byte(8'h96, a);
    wr_byte(8'h20, a);
    wr_byte(8'h44, a); wr_byte(8'h55, a);
    i2c_stop();
    exp_rf[32] = 8'h55;
    chk("R8 fixed r32", rf[32], exp_rf[32]);
    chk("R8 fixed r33 untouched", rf[33], exp_rf[33]);

    // incrementing read after repeated start
    i2c_start();
    wr_byte(8'h96, a);
    wr_byte(8'h90, a);
    i2c_start();
    wr_byte(8'h97, a); chk("R9 read addr ack", {7'd0, a}, 8'h01);
    expect_rd(exp_rf[16], "R9 read r16");
    expect_rd(exp_rf[17], "R10 read r17");
    expect_rd(exp_rf[18], "R10 read r18");
    rd_byte(1'b1); rd_byte(1'b1); rd_byte(1'b0);
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, s);
      chk("R11 released after nack", {7'd0, s}, 8'h01);
    end
    i2c_stop();

    // fixed-pointer read repeats one register
    i2c_start();
    wr_byte(8'h96, a);
    wr_byte(8'h20, a);
    i2c_start();
    wr_byte(8'h97, a);
    expect_rd(exp_rf[32], "R10 fixed read 1");
    expect_rd(exp_rf[32], "R10 fixed read 2");
    rd_byte(1'b1); rd_byte(1'b0);
    i2c_stop();

    // stop in the middle of a data byte
    i2c_start();
    wr_byte(8'h96, a);
    wr_byte(8'h40, a);
    clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
    i2c_stop();
    chk("R12 partial dropped", rf[64], exp_rf[64]);
    chk("R12 idle after stop", {7'd0, sda_oe}, 8'h00);
    i2c_start();
    wr_byte(8'h96, a);
    wr_byte(8'h41, a);
    wr_byte(8'h77, a); chk("R12 ack after stop", {7'd0, a}, 8'h01);
    i2c_stop();
    exp_rf[65] = 8'h77;
    chk("R12 write after stop", rf[65], exp_rf[65]);

    // start in the middle of a byte
    i2c_start();
    wr_byte(8'h96, a);
    clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
    i2c_start();
    wr_byte(8'h96, a); chk("R13 addr after restart", {7'd0, a}, 8'h01);
    wr_byte(8'h50, a);
    wr_byte(8'h66, a);
    i2c_stop();
    exp_rf[80] = 8'h66;
    chk("R13 write after restart", rf[80], exp_rf[80]);

    repeat (20) @(negedge clk);
    chk("R9 scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule